// File: doc/BRIEF.md
# Dual-Rate CAN FD Bit Timing Generator

This block produces the time-quantum ticks, the bit-start strobes and the sample-point strobes for a CAN FD controller. It holds two bit-timing sets. The slow set applies while arbitration runs. The fast set applies in the data phase. Each set has a prescaler, a first segment (propagation plus phase 1) and a second segment (phase 2). The protocol engine reports frame events: the rate-switch bit being sampled together with its level, the CRC delimiter, and a detected error. From these events the block decides which set times the next bit.

A switch never cuts a bit short. The set chosen during a bit takes over at the following bit boundary. If the rate-switch bit is recessive, the data phase runs on the fast set. Reaching the CRC delimiter, or any error, returns the block to the slow set, whichever of the two comes first. Configuration is captured only while the generator is held off. Resynchronisation, transceiver delay compensation, stuffing and CRC are handled elsewhere.

Top module: `canfd_bitrate_timer`

## Requirements
- R1: One time quantum lasts (prescaler + 1) clock cycles. `tq_tick` is high on the last cycle of each quantum, so after `bit_start` the first tick comes `prescaler` cycles later.
- R2: A bit is one sync quantum, then (seg1 + 2) quanta, then (seg2 + 1) quanta, so it lasts (seg1 + seg2 + 4)·(prescaler + 1) cycles. `bit_start` is high on the first cycle of every bit.
- R3: `sample_pt` is high on the last cycle of the first segment, (seg1 + 3)·(prescaler + 1) − 1 cycles after `bit_start`. It always coincides with a `tq_tick`.
- R4: After reset, and one cycle after `gen_off` is raised, all strobes are low and `fast_phase` is low. One cycle after `gen_off` falls, `bit_start` is high.
- R5: The timing inputs are captured only while `gen_off` is high. Changes made while running do not alter the bit timing.
- R6: A `brs_strobe` with `brs_recessive` = 1 makes the bits that follow the current bit use the fast set, with `fast_phase` high.
- R7: A `brs_strobe` with `brs_recessive` = 0 (dominant) leaves the slow set in use.
- R8: A `crc_delim` pulse during the fast phase brings back the slow set, with `fast_phase` low, from the next bit boundary.
- R9: A `frame_err` pulse brings back the slow set from the next bit boundary. When it arrives in the same cycle as a rate-switch request, it wins.
- R10: `fast_phase` changes only on a `bit_start` cycle and never within a bit.
- R11: The shortest bit is 4 quanta. With prescaler 0 and both segment fields 0, a bit lasts 4 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CAN clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_off | input | 1 | Holds the generator idle and captures the timing inputs |
| nom_pre | input | PRE_W | Slow-set prescaler (quantum = value + 1 clocks) |
| nom_seg1 | input | S1_W | Slow-set first segment (value + 2 quanta) |
| nom_seg2 | input | S2_W | Slow-set second segment (value + 1 quanta) |
| fast_pre | input | PRE_W | Fast-set prescaler |
| fast_seg1 | input | S1_W | Fast-set first segment |
| fast_seg2 | input | S2_W | Fast-set second segment |
| brs_strobe | input | 1 | Rate-switch bit has been sampled |
| brs_recessive | input | 1 | Level of the sampled rate-switch bit (1 = recessive) |
| crc_delim | input | 1 | CRC delimiter reached |
| frame_err | input | 1 | Protocol error detected |
| tq_tick | output | 1 | Last cycle of a time quantum |
| bit_start | output | 1 | First cycle of a bit |
| sample_pt | output | 1 | Sample point (end of first segment) |
| fast_phase | output | 1 | High while the fast set times the bits |

## Verification
Some rules are checked on every cycle. A sample point always sits on a quantum tick and never on a bit start. The generator stays quiet once it is held off. The phase indicator moves only at bit starts, rises only after an accepted recessive rate-switch request, and is low at the first bit start after a fallback event. Other rules can only be shown by the bench scenarios. These are the exact lengths of quanta, bits and sample offsets for several timing sets, the 4-quantum minimum, the dominant rate-switch case, the priority of an error over a same-cycle request, and the fact that timing inputs changed while running have no effect.

// File: rtl/canfd_bitrate_timer.sv
module canfd_bitrate_timer #(
  parameter int PRE_W = 8,
  parameter int S1_W  = 6,
  parameter int S2_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_off,
  input  logic [PRE_W-1:0] nom_pre,
  input  logic [S1_W-1:0]  nom_seg1,
  input  logic [S2_W-1:0]  nom_seg2,
  input  logic [PRE_W-1:0] fast_pre,
  input  logic [S1_W-1:0]  fast_seg1,
  input  logic [S2_W-1:0]  fast_seg2,
  input  logic             brs_strobe,
  input  logic             brs_recessive,
  input  logic             crc_delim,
  input  logic             frame_err,
  output logic             tq_tick,
  output logic             bit_start,
  output logic             sample_pt,
  output logic             fast_phase
);
  localparam int QC_W = ((S1_W > S2_W) ? S1_W : S2_W) + 2;

  logic [PRE_W-1:0] n_pre_q, f_pre_q, pc;
  logic [S1_W-1:0]  n_s1_q, f_s1_q;
  logic [S2_W-1:0]  n_s2_q, f_s2_q;
  logic [QC_W-1:0]  qc;
  logic             run, fast_q, want_q;

  wire [PRE_W-1:0] cur_pre = fast_q ? f_pre_q : n_pre_q;
  wire [S1_W-1:0]  cur_s1  = fast_q ? f_s1_q  : n_s1_q;
  wire [S2_W-1:0]  cur_s2  = fast_q ? f_s2_q  : n_s2_q;
  wire [QC_W-1:0]  seg1_end = QC_W'(cur_s1) + QC_W'(2);
  wire [QC_W-1:0]  bit_last = QC_W'(cur_s1) + QC_W'(cur_s2) + QC_W'(3);

  wire tick     = run && (pc == cur_pre);
  wire bit_done = tick && (qc == bit_last);
  wire fall_bk  = crc_delim || frame_err;
  wire want_nx  = fall_bk ? 1'b0 : ((brs_strobe && brs_recessive) ? 1'b1 : want_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; pc <= '0; qc <= '0; fast_q <= 1'b0; want_q <= 1'b0;
      n_pre_q <= '0; n_s1_q <= '0; n_s2_q <= '0;
      f_pre_q <= '0; f_s1_q <= '0; f_s2_q <= '0;
    end else if (gen_off) begin
      run <= 1'b0; pc <= '0; qc <= '0; fast_q <= 1'b0; want_q <= 1'b0;
      n_pre_q <= nom_pre;  n_s1_q <= nom_seg1;  n_s2_q <= nom_seg2;
      f_pre_q <= fast_pre; f_s1_q <= fast_seg1; f_s2_q <= fast_seg2;
    end else begin
      run <= 1'b1;
      if (run) begin
        want_q <= want_nx;
        if (tick) begin
          pc <= '0;
          if (bit_done) begin
            qc     <= '0;
            fast_q <= want_nx;
          end else begin
            qc <= qc + QC_W'(1);
          end
        end else begin
          pc <= pc + PRE_W'(1);
        end
      end
    end
  end

  assign tq_tick    = tick;
  assign bit_start  = run && (pc == '0) && (qc == '0);
  assign sample_pt  = tick && (qc == seg1_end);
  assign fast_phase = fast_q;
endmodule

module canfd_bitrate_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic gen_off,
  input logic brs_strobe,
  input logic brs_recessive,
  input logic crc_delim,
  input logic frame_err,
  input logic tq_tick,
  input logic bit_start,
  input logic sample_pt,
  input logic fast_phase
);
  logic brs_seen, fb_pend;
  wire  fb_ev  = !gen_off && (crc_delim || frame_err);
  wire  brs_ok = !gen_off && brs_strobe && brs_recessive && !fb_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brs_seen <= 1'b0; fb_pend <= 1'b0;
    end else if (gen_off) begin
      brs_seen <= 1'b0; fb_pend <= 1'b0;
    end else begin
      if (fb_ev) brs_seen <= 1'b0;
      else if (brs_ok) brs_seen <= 1'b1;
      if (fb_ev) fb_pend <= 1'b1;
      else if (bit_start || brs_ok) fb_pend <= 1'b0;
    end
  end

  AST_SAMPLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) sample_pt |-> tq_tick); // R3
  AST_SAMPLE_NOT_START: assert property (@(posedge clk) disable iff (!rst_n) sample_pt |-> !bit_start); // R3
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) gen_off |=> (!tq_tick && !bit_start && !sample_pt && !fast_phase)); // R4
  AST_PHASE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (!gen_off && !$past(gen_off) && (fast_phase != $past(fast_phase))) |-> bit_start); // R10
  AST_FAST_NEEDS_BRS: assert property (@(posedge clk) disable iff (!rst_n) $rose(fast_phase) |-> brs_seen); // R6
  AST_FALLBACK_DONE: assert property (@(posedge clk) disable iff (!rst_n) (bit_start && fb_pend) |-> !fast_phase); // R8
endmodule

bind canfd_bitrate_timer canfd_bitrate_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gen_off(gen_off),
  .brs_strobe(brs_strobe), .brs_recessive(brs_recessive),
  .crc_delim(crc_delim), .frame_err(frame_err),
  .tq_tick(tq_tick), .bit_start(bit_start), .sample_pt(sample_pt), .fast_phase(fast_phase)
);

// File: tb/canfd_bitrate_timer_test.sv
`timescale 1ns/1ps
module canfd_bitrate_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, gen_off = 1'b1;
  logic [7:0] nom_pre = '0, fast_pre = '0;
  logic [5:0] nom_seg1 = '0, fast_seg1 = '0;
  logic [4:0] nom_seg2 = '0, fast_seg2 = '0;
  logic brs_strobe = 1'b0, brs_recessive = 1'b0, crc_delim = 1'b0, frame_err = 1'b0;
  logic tq_tick, bit_start, sample_pt, fast_phase;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  canfd_bitrate_timer uut (
    .clk(clk), .rst_n(rst_n), .gen_off(gen_off),
    .nom_pre(nom_pre), .nom_seg1(nom_seg1), .nom_seg2(nom_seg2),
    .fast_pre(fast_pre), .fast_seg1(fast_seg1), .fast_seg2(fast_seg2),
    .brs_strobe(brs_strobe), .brs_recessive(brs_recessive),
    .crc_delim(crc_delim), .frame_err(frame_err),
    .tq_tick(tq_tick), .bit_start(bit_start), .sample_pt(sample_pt), .fast_phase(fast_phase)
  );

  // pre, seg1, seg2, first tick offset, bit length, sample offset
  localparam int VEC [5][6] = '{
    '{0, 0,  0, 0,  4,  2},
    '{1, 2,  1, 1, 14,  9},
    '{3, 4,  2, 3, 40, 27},
    '{4, 10, 5, 4, 95, 64},
    '{2, 1,  7, 2, 36, 11}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_bit();
    do @(negedge clk); while (!bit_start);
  endtask

  task automatic wait_sample();
    do @(negedge clk); while (!sample_pt);
  endtask

  // called on a bit_start negedge; returns at the next bit_start
  task automatic meas(output int t, output int s, output int p);
    int c = 0;
    t = -1; s = -1;
    forever begin
      if (tq_tick && t < 0) t = c;
      if (sample_pt && s < 0) s = c;
      @(negedge clk); c++;
      if (bit_start) break;
    end
    p = c;
  endtask

  task automatic restart(input int np, input int n1, input int n2);
    @(negedge clk);
    gen_off = 1'b1;
    nom_pre = 8'(np); nom_seg1 = 6'(n1); nom_seg2 = 5'(n2);
    fast_pre = 8'd0; fast_seg1 = 6'd0; fast_seg2 = 5'd0;
    @(negedge clk); @(negedge clk);
    gen_off = 1'b0;
  endtask

  task automatic pulse_brs(input logic lvl);
    wait_sample();
    brs_strobe = 1'b1; brs_recessive = lvl;
    @(negedge clk);
    brs_strobe = 1'b0; brs_recessive = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t, s, p, strobes;
    @(negedge clk);
    check(!tq_tick && !bit_start && !sample_pt && !fast_phase, "R4 reset quiet", int'(bit_start), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 5; i++) begin
      restart(VEC[i][0], VEC[i][1], VEC[i][2]);
      @(negedge clk);
      check(bit_start == 1'b1, "R4 first bit after release", int'(bit_start), 1);
      meas(t, s, p);
      check(t == VEC[i][3], "R1 quantum length", t, VEC[i][3]);
      check(s == VEC[i][5], "R3 sample offset", s, VEC[i][5]);
      check(p == VEC[i][4], "R2 bit length", p, VEC[i][4]);
      check(!fast_phase, "R7 stays nominal without request", int'(fast_phase), 0);
    end

    // R5: change while running has no effect
    restart(3, 4, 2);
    wait_bit();
    nom_pre = 8'd0; nom_seg1 = 6'd9;
    wait_bit();
    meas(t, s, p);
    check(p == 40, "R5 config frozen while running", p, 40);

    // R6, R10, R11: recessive rate switch
    restart(3, 4, 2);
    wait_bit();
    pulse_brs(1'b1);
    check(!fast_phase, "R10 no mid-bit switch", int'(fast_phase), 0);
    wait_bit();
    check(fast_phase, "R6 fast after recessive switch bit", int'(fast_phase), 1);
    meas(t, s, p);
    check(p == 4, "R11 minimum 4-quantum bit", p, 4);
    check(s == 2, "R6 fast sample offset", s, 2);

    // R8: CRC delimiter fallback
    crc_delim = 1'b1; @(negedge clk); crc_delim = 1'b0;
    check(fast_phase, "R10 fast held until boundary", int'(fast_phase), 1);
    wait_bit();
    check(!fast_phase, "R8 nominal after CRC delimiter", int'(fast_phase), 0);
    meas(t, s, p);
    check(p == 40, "R8 nominal bit length", p, 40);

    // R7: dominant switch bit
    pulse_brs(1'b0);
    wait_bit();
    check(!fast_phase, "R7 dominant keeps nominal", int'(fast_phase), 0);
    meas(t, s, p);
    check(p == 40, "R7 nominal bit length", p, 40);

    // R9: error fallback and priority
    pulse_brs(1'b1);
    wait_bit();
    check(fast_phase, "R9 fast before error", int'(fast_phase), 1);
    frame_err = 1'b1; @(negedge clk); frame_err = 1'b0;
    wait_bit();
    check(!fast_phase, "R9 nominal after error", int'(fast_phase), 0);
    wait_sample();
    frame_err = 1'b1; brs_strobe = 1'b1; brs_recessive = 1'b1;
    @(negedge clk);
    frame_err = 1'b0; brs_strobe = 1'b0; brs_recessive = 1'b0;
    wait_bit();
    check(!fast_phase, "R9 error beats same-cycle switch", int'(fast_phase), 0);

    // R4: disable while fast
    pulse_brs(1'b1);
    wait_bit();
    gen_off = 1'b1;
    @(negedge clk);
    strobes = 0;
    for (int k = 0; k < 20; k++) begin
      if (tq_tick || bit_start || sample_pt || fast_phase) strobes++;
      @(negedge clk);
    end
    check(strobes == 0, "R4 quiet while disabled", strobes, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule